// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block is the purely combinational front end of a simple byte-encoded 32-bit processor. Each cycle it is handed the program counter and the six bytes of instruction memory starting at that address (byte 0 is the byte at PC). From the opcode nibble of the first byte it works out whether a register-specifier byte and a four-byte constant follow. It then splits out the register fields, assembles the constant in little-endian order from the right offset and produces the address of the next sequential instruction.

Instructions are 1, 2, 5 or 6 bytes long. Absent register fields read as the "no register" code 8, and an absent constant reads as zero, so later stages can decode the fields without knowing the opcode. An opcode outside the defined set clears the valid output. Such an opcode is treated as a one-byte instruction with no optional fields.

Top module: `fetch_aligner`

## Requirements
- R1: `icode_o` equals the upper nibble of byte 0 and `ifun_o` equals its lower nibble, for every opcode.
- R2: For opcodes 2, 3, 4, 5, 6, 0xA and 0xB a register byte sits at byte 1: `ra_o` is its upper nibble and `rb_o` its lower nibble.
- R3: For every other opcode, including invalid ones, `ra_o` and `rb_o` both read 8 (no register).
- R4: For opcodes 3, 4, 5, 7 and 8 `const_o` is the little-endian 32-bit word made from four bytes. It starts at byte 2 when a register byte is present and at byte 1 otherwise.
- R5: For all other opcodes `const_o` is 0.
- R6: `next_pc_o` equals `pc_i` plus the length: 1, plus 1 for a register byte, plus 4 for a constant. The sum wraps modulo 2^32.
- R7: `valid_o` is 1 for opcodes 0 through 0xB and 0 for 0xC through 0xF. An invalid opcode yields a length of 1, register fields of 8 and a constant of 0.
- R8: Known encodings decode exactly. Bytes 30 82 cd ab 00 00 give `rb_o`=2, `const_o`=0x0000abcd and length 6. Bytes 50 15 f4 ff ff ff give `ra_o`=1, `rb_o`=5, `const_o`=0xfffffff4 and length 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the instruction being fetched |
| bytes_i | input | 48 | Six memory bytes; byte k (address PC+k) in bits 8k+7:8k |
| icode_o | output | 4 | Instruction code nibble |
| ifun_o | output | 4 | Function code nibble |
| ra_o | output | 4 | First register ID, or 8 when absent |
| rb_o | output | 4 | Second register ID, or 8 when absent |
| const_o | output | 32 | Assembled constant, or 0 when absent |
| next_pc_o | output | 32 | Address of the next sequential instruction |
| valid_o | output | 1 | Opcode belongs to the defined set |

## Verification
Two functions can land on the same decode: the register-byte shift of the constant window, and the addition of the constant's four bytes to the length. Only opcodes 3, 4 and 5 trigger both. These opcodes are driven with random payloads and with a negative displacement. Each result is judged by the bench's own reference function, which rebuilds the constant from the shifted offset and the length from both presence flags. The same vectors are also placed near the top of the address space, so the wrapping add is checked on 6-byte instructions.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int WORD_W      = 32;
    localparam int CONST_BYTES = WORD_W / 8;
    localparam int WIN_BYTES   = 2 + CONST_BYTES;
    localparam int LEN_W       = $clog2(WIN_BYTES + 1);
    localparam logic [3:0] NO_REG = 4'h8;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_RRMV  = 4'h2,
        OP_IRMV  = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB,
        OP_BADC  = 4'hC,
        OP_BADD  = 4'hD,
        OP_BADE  = 4'hE,
        OP_BADF  = 4'hF
    } op_e;

    typedef struct packed {
        logic valid;
        logic has_reg;
        logic has_const;
    } opclass_t;
endpackage

// File: rtl/fa_opclass.sv
module fa_opclass
    import fa_pkg::*;
(
    input  logic [3:0] icode_i,
    output opclass_t   cls_o
);
    opclass_t cls_d;

    always_comb begin
        cls_d = '0;
        case (op_e'(icode_i))
            OP_NOP, OP_HALT, OP_RET:        cls_d = '{valid: 1'b1, has_reg: 1'b0, has_const: 1'b0};
            OP_RRMV, OP_ALU, OP_PUSH, OP_POP: cls_d = '{valid: 1'b1, has_reg: 1'b1, has_const: 1'b0};
            OP_IRMV, OP_STORE, OP_LOAD:     cls_d = '{valid: 1'b1, has_reg: 1'b1, has_const: 1'b1};
            OP_JUMP, OP_CALL:               cls_d = '{valid: 1'b1, has_reg: 1'b0, has_const: 1'b1};
            default:                        cls_d = '0;
        endcase
    end

    assign cls_o = cls_d;
endmodule

// File: rtl/fa_regsplit.sv
module fa_regsplit
    import fa_pkg::*;
(
    input  logic       has_reg_i,
    input  logic [7:0] spec_i,
    output logic [3:0] ra_o,
    output logic [3:0] rb_o
);
    always_comb begin
        ra_o = NO_REG;
        rb_o = NO_REG;
        if (has_reg_i) begin
            ra_o = spec_i[7:4];
            rb_o = spec_i[3:0];
        end
    end
endmodule

// File: rtl/fa_const_align.sv
module fa_const_align
    import fa_pkg::*;
#(
    parameter int NBYTES = CONST_BYTES,
    localparam int TAIL_W = 8 * (NBYTES + 1)
) (
    input  logic                  has_reg_i,
    input  logic                  has_const_i,
    input  logic [TAIL_W-1:0]     tail_i,
    output logic [8*NBYTES-1:0]   const_o
);
    logic [8*NBYTES-1:0] picked_d;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        always_comb begin
            picked_d[8*k +: 8] = has_reg_i ? tail_i[8*(k+1) +: 8] : tail_i[8*k +: 8];
        end
    end

    assign const_o = has_const_i ? picked_d : '0;
endmodule

// File: rtl/fa_len_adder.sv
module fa_len_adder
    import fa_pkg::*;
(
    input  logic              has_reg_i,
    input  logic              has_const_i,
    input  logic [WORD_W-1:0] pc_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [WORD_W-1:0] next_pc_o
);
    always_comb begin
        len_o = LEN_W'(1);
        if (has_reg_i)   len_o = len_o + LEN_W'(1);
        if (has_const_i) len_o = len_o + LEN_W'(CONST_BYTES);
        next_pc_o = pc_i + WORD_W'(len_o);
    end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
(
    input  logic [31:0] pc_i,
    input  logic [47:0] bytes_i,
    output logic [3:0]  icode_o,
    output logic [3:0]  ifun_o,
    output logic [3:0]  ra_o,
    output logic [3:0]  rb_o,
    output logic [31:0] const_o,
    output logic [31:0] next_pc_o,
    output logic        valid_o
);
    opclass_t         cls;
    logic [LEN_W-1:0] len;

    assign icode_o = bytes_i[7:4];
    assign ifun_o  = bytes_i[3:0];

    fa_opclass u_cls (
        .icode_i (bytes_i[7:4]),
        .cls_o   (cls)
    );

    fa_regsplit u_regs (
        .has_reg_i (cls.has_reg),
        .spec_i    (bytes_i[15:8]),
        .ra_o      (ra_o),
        .rb_o      (rb_o)
    );

    fa_const_align #(.NBYTES(CONST_BYTES)) u_const (
        .has_reg_i   (cls.has_reg),
        .has_const_i (cls.has_const),
        .tail_i      (bytes_i[8*WIN_BYTES-1:8]),
        .const_o     (const_o)
    );

    fa_len_adder u_len (
        .has_reg_i   (cls.has_reg),
        .has_const_i (cls.has_const),
        .pc_i        (pc_i),
        .len_o       (len),
        .next_pc_o   (next_pc_o)
    );

    assign valid_o = cls.valid;

    always_comb begin
        // R6
        len_set_chk: assert (len == 1 || len == 2 || len == 5 || len == 6);
        // R3
        no_reg_byte_chk: assert (!(len == 1 || len == 5) || (ra_o == NO_REG && rb_o == NO_REG));
        // R5
        no_const_chk: assert (!(len == 1 || len == 2) || const_o == '0);
        // R7
        invalid_len_chk: assert (valid_o || (next_pc_o == pc_i + 32'd1));
    end
endmodule

// File: tb/fetch_aligner_tb_top.sv
module fetch_aligner_tb_top;
    logic        clk = 1'b0;
    logic [31:0] pc;
    logic [47:0] bytes;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] cval, npc;
    logic        valid;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fetch_aligner dut_i (
        .pc_i(pc), .bytes_i(bytes), .icode_o(icode), .ifun_o(ifun),
        .ra_o(ra), .rb_o(rb), .const_o(cval), .next_pc_o(npc), .valid_o(valid)
    );

    function automatic bit ref_reg(input logic [3:0] op);
        return op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
    endfunction
    function automatic bit ref_const(input logic [3:0] op);
        return op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
    endfunction
    function automatic logic [7:0] byte_at(input logic [47:0] b, input int k);
        return b[8*k +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (pc=%h bytes=%h)", req, act, exp, pc, bytes);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [47:0] b);
        logic [3:0]  op;
        bit          hr, hc;
        int          off;
        logic [31:0] ec;
        logic [31:0] elen;
        @(posedge clk);
        pc = p;
        bytes = b;
        @(negedge clk);
        op = b[7:4];
        hr = ref_reg(op);
        hc = ref_const(op);
        off = hr ? 2 : 1;
        ec = hc ? {byte_at(b, off+3), byte_at(b, off+2), byte_at(b, off+1), byte_at(b, off)} : 32'h0;
        elen = 32'd1 + (hr ? 32'd1 : 32'd0) + (hc ? 32'd4 : 32'd0);
        chk("R1 icode", {28'h0, icode}, {28'h0, op});
        chk("R1 ifun", {28'h0, ifun}, {28'h0, b[3:0]});
        if (hr) begin
            chk("R2 ra", {28'h0, ra}, {28'h0, b[15:12]});
            chk("R2 rb", {28'h0, rb}, {28'h0, b[11:8]});
        end else begin
            chk("R3 ra", {28'h0, ra}, 32'h8);
            chk("R3 rb", {28'h0, rb}, 32'h8);
        end
        if (hc) chk("R4 const", cval, ec);
        else    chk("R5 const", cval, 32'h0);
        chk("R6 next_pc", npc, p + elen);
        chk("R7 valid", {31'h0, valid}, {31'h0, (op <= 4'hB)});
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h0000_5eed);
        pc = '0;
        bytes = '0;
        @(negedge clk);
        // R1 R5 R6: idle all-zero inputs decode as a one-byte nop
        chk("R6 idle next_pc", npc, 32'h1);
        chk("R5 idle const", cval, 32'h0);
        chk("R7 idle valid", {31'h0, valid}, 32'h1);

        // R8 directed encodings
        apply(32'h0000_0100, 48'h0000_abcd_8230);
        chk("R8 irmov rb", {28'h0, rb}, 32'h2);
        chk("R8 irmov const", cval, 32'h0000abcd);
        chk("R8 irmov len", npc, 32'h0000_0106);
        apply(32'h0000_0040, 48'hffff_fff4_1550);
        chk("R8 load ra", {28'h0, ra}, 32'h1);
        chk("R8 load rb", {28'h0, rb}, 32'h5);
        chk("R8 load const", cval, 32'hfffffff4);
        chk("R8 load len", npc, 32'h0000_0046);
        apply(32'h0000_0010, 48'h0000_0000_2880);   // call, 5 bytes
        apply(32'h0000_0000, 48'h0000_0000_0020 | 48'h4300); // rrmov
        apply(32'h0000_0000, 48'hffff_ffff_ff10);   // halt
        apply(32'h0000_0000, 48'hffff_ffff_ff90);   // ret
        apply(32'h0000_0000, 48'h0000_0000_28a0);   // push
        // R6 wrap at top of address space
        apply(32'hffff_fffd, 48'h1234_5678_9a40);
        chk("R6 wrap store", npc, 32'h0000_0003);
        apply(32'hffff_ffff, 48'h0000_0000_0000);
        chk("R6 wrap nop", npc, 32'h0000_0000);
        // R7 invalid opcodes
        for (int k = 12; k < 16; k++) apply(32'h0000_0200, {40'hff_ffff_ffff, k[3:0], 4'h7});

        // constrained random: mostly valid opcodes, some invalid, some near wrap
        for (int i = 0; i < 3000; i++) begin
            logic [47:0] b;
            logic [31:0] p;
            logic [3:0]  op;
            b = {$urandom, $urandom};
            op = ($urandom_range(0, 9) == 0) ? 4'(12 + $urandom_range(0, 3)) : 4'($urandom_range(0, 11));
            if (i % 3 == 0) op = 4'(3 + (i % 9) / 3);     // stress reg+const opcodes
            b[7:4] = op;
            p = ($urandom_range(0, 7) == 0) ? 32'hffff_fff8 + 32'($urandom_range(0, 7)) : $urandom;
            apply(p, b);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule